// File: doc/BRIEF.md
# Privileged Time-Stamp Counter Unit

This unit holds a free-running cycle counter that starts from zero at reset and advances by one on every clock. An instruction-execution front end sends it read requests. Each request carries the processor mode, the current privilege level, a time-stamp-disable control bit and the request kind. The kind is either the dedicated counter-read instruction or a read through the model-specific-register path.

An access gate checks each request and the unit answers exactly one cycle later. A permitted request returns the count sampled on the request edge, split into a high word and a low word taken from the same sample. A refused request raises a general-protection fault with error code zero, and the data outputs are left untouched. The unit never waits for earlier work to finish, so a request can be issued on every cycle.

Top module: `tsc_unit`

## Requirements
- R1: The counter advances by one on every clock edge out of reset. From all ones it wraps to zero, and no flag or output marks the wrap.
- R2: While reset is high the counter is cleared to zero and rsp_valid, rsp_data_valid, rsp_fault, rsp_hi and rsp_lo are all driven to zero. The first read after reset returns a count equal to the number of clock edges since reset was released.
- R3: A request taken on a clock edge (req_valid high) is answered on the next edge with rsp_valid high for one cycle. A permitted read places bits [CNT_W-1:CNT_W/2] of the count sampled on the request edge on rsp_hi and the lower half on rsp_lo.
- R4: In protected mode (req_mode 0) with the disable bit (req_tsd) clear, the counter-read instruction (req_kind 0) is permitted at every privilege level 0 to 3.
- R5: In protected mode with the disable bit set, the counter-read instruction is permitted only at privilege level 0. At levels 1, 2 and 3 it faults with error code 0 and rsp_fault_has_code high.
- R6: In real-address mode (req_mode 1) the counter-read instruction faults when the disable bit is set, and is otherwise permitted. A real-address fault does not carry an error code (rsp_fault_has_code low).
- R7: In virtual-8086 mode (req_mode 2) the counter-read instruction faults with error code 0 and rsp_fault_has_code high when the disable bit is set, and is otherwise permitted at any privilege level.
- R8: A register-path read (req_kind 1) is permitted only at privilege 0, that is in protected mode at level 0 or in real-address mode, whatever the disable bit. In protected mode at levels 1 to 3 and in virtual-8086 mode it faults with error code 0 and a code present.
- R9: A fault response raises rsp_fault and rsp_valid together for one cycle, keeps rsp_data_valid low and leaves rsp_hi and rsp_lo at their previous values.
- R10: The reserved mode encoding (req_mode 3) makes every request fault with error code 0 and a code present.
- R11: Requests on consecutive cycles each get their own response on consecutive cycles. Each response carries its own sample, so consecutive permitted reads differ by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A read request is presented this cycle |
| req_kind | input | 1 | 0 = counter-read instruction, 1 = register-path read |
| req_mode | input | 2 | 0 protected, 1 real-address, 2 virtual-8086, 3 reserved |
| req_cpl | input | 2 | Current privilege level |
| req_tsd | input | 1 | Time-stamp-disable control bit |
| rsp_valid | output | 1 | A response is presented this cycle |
| rsp_data_valid | output | 1 | The response carries count data |
| rsp_hi | output | CNT_W/2 | Upper half of the sampled count |
| rsp_lo | output | CNT_W/2 | Lower half of the sampled count |
| rsp_fault | output | 1 | The response is a general-protection fault |
| rsp_fault_has_code | output | 1 | The fault carries an error code |
| rsp_fault_code | output | 16 | Error code of the fault (always 0) |

## Verification
The assertions assume that req_kind, req_mode, req_cpl and req_tsd hold known values whenever req_valid is high, and that the count is only observed through the registered response. They also assume that reset is held for at least one edge before any property depends on the past. The stimulus changes inputs only on falling edges and sweeps every combination of kind, mode, privilege level and disable bit, including the reserved mode. Random requests are then mixed with idle cycles and an extra reset, so the antecedents of the gate properties are all reached with legal, fully known inputs.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    localparam int unsigned ERR_W = 16;

    typedef enum logic [1:0] {
        MODE_PROT = 2'd0,
        MODE_REAL = 2'd1,
        MODE_V86  = 2'd2,
        MODE_RSVD = 2'd3
    } cpu_mode_e;

    typedef enum logic {
        KIND_TSREAD = 1'b0,
        KIND_MSR    = 1'b1
    } rd_kind_e;

    typedef struct packed {
        logic allow;
        logic has_code;
    } gate_t;

    // Access rule for one read request.
    function automatic gate_t check_access(rd_kind_e kind, cpu_mode_e mode,
                                           logic [1:0] cpl, logic tsd);
        gate_t g;
        g.has_code = (mode != MODE_REAL);
        g.allow    = 1'b0;
        if (kind == KIND_MSR) begin
            g.allow = (mode == MODE_REAL) || (mode == MODE_PROT && cpl == 2'd0);
        end else begin
            case (mode)
                MODE_PROT: g.allow = !tsd || (cpl == 2'd0);
                MODE_REAL: g.allow = !tsd;
                MODE_V86:  g.allow = !tsd;
                default:   g.allow = 1'b0;
            endcase
        end
        return g;
    endfunction

endpackage

// File: rtl/tsc_counter.sv
module tsc_counter #(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + ONE;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/tsc_gate.sv
module tsc_gate
    import tsc_pkg::*;
(
    input  logic       kind,
    input  logic [1:0] mode,
    input  logic [1:0] cpl,
    input  logic       tsd,
    output logic       allow,
    output logic       has_code
);
    gate_t g;

    always_comb begin
        g        = check_access(rd_kind_e'(kind), cpu_mode_e'(mode), cpl, tsd);
        allow    = g.allow;
        has_code = g.has_code;
    end
endmodule

// File: rtl/tsc_resp.sv
module tsc_resp
    import tsc_pkg::*;
#(
    parameter int unsigned HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                allow,
    input  logic                has_code,
    input  logic [2*HALF_W-1:0] sample,
    output logic                rsp_valid,
    output logic                rsp_data_valid,
    output logic [HALF_W-1:0]   rsp_hi,
    output logic [HALF_W-1:0]   rsp_lo,
    output logic                rsp_fault,
    output logic                rsp_fault_has_code,
    output logic [ERR_W-1:0]    rsp_fault_code
);
    logic take, refuse;

    assign take   = req_valid && allow;
    assign refuse = req_valid && !allow;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid          <= 1'b0;
            rsp_data_valid     <= 1'b0;
            rsp_fault          <= 1'b0;
            rsp_fault_has_code <= 1'b0;
            rsp_fault_code     <= '0;
            rsp_hi             <= '0;
            rsp_lo             <= '0;
        end else begin
            rsp_valid          <= req_valid;
            rsp_data_valid     <= take;
            rsp_fault          <= refuse;
            rsp_fault_has_code <= refuse && has_code;
            if (refuse) rsp_fault_code <= '0;
            if (take) begin
                rsp_hi <= sample[2*HALF_W-1:HALF_W];
                rsp_lo <= sample[HALF_W-1:0];
            end
        end
    end
endmodule

// File: rtl/tsc_unit.sv
module tsc_unit
    import tsc_pkg::*;
#(
    parameter  int unsigned CNT_W  = 64,
    localparam int unsigned HALF_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_kind,
    input  logic [1:0]        req_mode,
    input  logic [1:0]        req_cpl,
    input  logic              req_tsd,
    output logic              rsp_valid,
    output logic              rsp_data_valid,
    output logic [HALF_W-1:0] rsp_hi,
    output logic [HALF_W-1:0] rsp_lo,
    output logic              rsp_fault,
    output logic              rsp_fault_has_code,
    output logic [ERR_W-1:0]  rsp_fault_code
);
    logic [CNT_W-1:0] cnt_now;
    logic             gate_allow;
    logic             gate_code;

    tsc_counter #(.CNT_W(CNT_W)) u_counter (
        .clk   (clk),
        .rst   (rst),
        .cnt_o (cnt_now)
    );

    tsc_gate u_gate (
        .kind     (req_kind),
        .mode     (req_mode),
        .cpl      (req_cpl),
        .tsd      (req_tsd),
        .allow    (gate_allow),
        .has_code (gate_code)
    );

    tsc_resp #(.HALF_W(HALF_W)) u_resp (
        .clk                (clk),
        .rst                (rst),
        .req_valid          (req_valid),
        .allow              (gate_allow),
        .has_code           (gate_code),
        .sample             (cnt_now),
        .rsp_valid          (rsp_valid),
        .rsp_data_valid     (rsp_data_valid),
        .rsp_hi             (rsp_hi),
        .rsp_lo             (rsp_lo),
        .rsp_fault          (rsp_fault),
        .rsp_fault_has_code (rsp_fault_has_code),
        .rsp_fault_code     (rsp_fault_code)
    );
endmodule

// File: rtl/tsc_unit_chk.sv
module tsc_unit_chk #(
    parameter int unsigned CNT_W  = 64,
    parameter int unsigned HALF_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_kind,
    input logic [1:0]        req_mode,
    input logic [1:0]        req_cpl,
    input logic              req_tsd,
    input logic [CNT_W-1:0]  cnt_now,
    input logic              rsp_valid,
    input logic              rsp_data_valid,
    input logic              rsp_fault,
    input logic              rsp_fault_has_code,
    input logic [HALF_W-1:0] rsp_hi,
    input logic [HALF_W-1:0] rsp_lo
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic armed;
    logic rst_q;

    always_ff @(posedge clk) begin
        armed <= !rst;
        rst_q <= rst;
    end

    p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
        armed |-> cnt_now == $past(cnt_now) + ONE);

    p_reset_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (cnt_now == '0 && !rsp_valid && rsp_hi == '0 && rsp_lo == '0));

    p_latency_r3: assert property (@(posedge clk) disable iff (rst)
        armed |-> rsp_valid == $past(req_valid));

    p_sample_r3: assert property (@(posedge clk) disable iff (rst)
        (armed && rsp_data_valid) |-> {rsp_hi, rsp_lo} == $past(cnt_now));

    p_prot_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(req_valid && !req_kind && req_mode == 2'd0 && req_tsd && req_cpl != 2'd0))
        |-> (rsp_fault && rsp_fault_has_code));

    p_msr_gate_r8: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(req_valid && req_kind && req_mode == 2'd2)) |-> rsp_fault);

    p_fault_shape_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_valid && !rsp_data_valid));

    p_fault_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (armed && rsp_fault) |-> ($stable(rsp_hi) && $stable(rsp_lo)));

    p_one_kind_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({rsp_fault, rsp_data_valid}) == 1);
endmodule

bind tsc_unit tsc_unit_chk #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_chk (
    .clk                (clk),
    .rst                (rst),
    .req_valid          (req_valid),
    .req_kind           (req_kind),
    .req_mode           (req_mode),
    .req_cpl            (req_cpl),
    .req_tsd            (req_tsd),
    .cnt_now            (cnt_now),
    .rsp_valid          (rsp_valid),
    .rsp_data_valid     (rsp_data_valid),
    .rsp_fault          (rsp_fault),
    .rsp_fault_has_code (rsp_fault_has_code),
    .rsp_hi             (rsp_hi),
    .rsp_lo             (rsp_lo)
);

// File: tb/tsc_unit_bench.sv
module tsc_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_kind = 1'b0;
    logic [1:0]  req_mode = 2'd0;
    logic [1:0]  req_cpl = 2'd0;
    logic        req_tsd = 1'b0;
    logic        rsp_valid, rsp_data_valid, rsp_fault, rsp_fault_has_code;
    logic [31:0] rsp_hi, rsp_lo;
    logic [15:0] rsp_fault_code;

    logic        s_valid, s_dv, s_fault, s_hc;
    logic [7:0]  s_hi, s_lo;
    logic [15:0] s_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsc_unit u_tsc_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_mode(req_mode), .req_cpl(req_cpl), .req_tsd(req_tsd),
        .rsp_valid(rsp_valid), .rsp_data_valid(rsp_data_valid),
        .rsp_hi(rsp_hi), .rsp_lo(rsp_lo), .rsp_fault(rsp_fault),
        .rsp_fault_has_code(rsp_fault_has_code), .rsp_fault_code(rsp_fault_code)
    );

    // Narrow copy so the wrap can be reached in a short run.
    tsc_unit #(.CNT_W(16)) u_tsc_unit_w16 (
        .clk(clk), .rst(rst), .req_valid(1'b1), .req_kind(1'b0),
        .req_mode(2'd0), .req_cpl(2'd0), .req_tsd(1'b0),
        .rsp_valid(s_valid), .rsp_data_valid(s_dv),
        .rsp_hi(s_hi), .rsp_lo(s_lo), .rsp_fault(s_fault),
        .rsp_fault_has_code(s_hc), .rsp_fault_code(s_code)
    );

    // Reference counts from R1/R2.
    logic [63:0] exp_cnt;
    logic [15:0] exp16;
    always_ff @(posedge clk) begin
        exp_cnt <= rst ? 64'd0 : exp_cnt + 64'd1;
        exp16   <= rst ? 16'd0 : exp16 + 16'd1;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
        end
    endtask

    function automatic bit ref_allow(input logic k, input logic [1:0] m, input logic [1:0] c, input logic t);
        if (k) return (m == 2'd1) || (m == 2'd0 && c == 2'd0);   // R8
        if (m == 2'd0) return (t == 1'b0) || (c == 2'd0);        // R4, R5
        if (m == 2'd1 || m == 2'd2) return (t == 1'b0);          // R6, R7
        return 1'b0;                                             // R10
    endfunction

    function automatic string auto_tag(input logic k, input logic [1:0] m, input logic t);
        if (k) return "R8";
        case (m)
            2'd0:    return t ? "R5" : "R4";
            2'd1:    return "R6";
            2'd2:    return "R7";
            default: return "R10";
        endcase
    endfunction

    // Pending expectation for the response due on the next falling edge.
    bit          p_valid = 0;
    bit          p_allow = 0;
    bit          p_code  = 0;
    logic [63:0] p_data  = '0;
    string       p_tag   = "";
    logic [63:0] last_good = '0;

    task automatic check_pending();
        logic [4:0] act_st, exp_st;
        act_st = {rsp_valid, rsp_data_valid, rsp_fault, rsp_fault_has_code, rsp_fault_code == 16'd0};
        if (p_valid) begin
            exp_st = {1'b1, p_allow, !p_allow, !p_allow && p_code, 1'b1};
            chk(act_st == exp_st, p_tag, {59'd0, act_st}, {59'd0, exp_st});
            chk({rsp_hi, rsp_lo} == p_data, p_allow ? "R3" : "R9", {rsp_hi, rsp_lo}, p_data);
        end else begin
            chk(!rsp_valid && !rsp_fault && !rsp_data_valid, "R3", {59'd0, act_st}, 64'd0);
        end
    endtask

    // Called on a falling edge; returns on the next falling edge.
    task automatic step(input logic v, input logic k, input logic [1:0] m,
                        input logic [1:0] c, input logic t, input string tag);
        check_pending();
        req_valid = v; req_kind = k; req_mode = m; req_cpl = c; req_tsd = t;
        p_valid = v;
        if (v) begin
            p_allow = ref_allow(k, m, c, t);
            p_code  = (m != 2'd1);
            p_tag   = (tag == "") ? auto_tag(k, m, t) : tag;
            if (p_allow) last_good = exp_cnt;
            p_data  = last_good;
        end
        @(negedge clk);
    endtask

    task automatic do_reset(input int cycles);
        req_valid = 0;
        rst = 1;
        repeat (cycles) @(negedge clk);
        rst = 0;
        p_valid = 0;
        last_good = '0;
        // R2: outputs cleared right after reset
        chk(!rsp_valid && !rsp_fault && !rsp_data_valid && rsp_hi == 0 && rsp_lo == 0,
            "R2", {rsp_hi, rsp_lo}, 64'd0);
    endtask

    // R1: wrap of the narrow counter, seen through its responses.
    logic [15:0] s_snap;
    bit          s_have = 0;
    always @(negedge clk) begin
        if (rst) begin
            s_have = 0;
        end else begin
            if (s_have && (s_snap == 16'hFFFF || s_snap == 16'h0000 || s_snap == 16'hFFFE))
                chk(s_valid && s_dv && {s_hi, s_lo} == s_snap, "R1",
                    {48'd0, s_hi, s_lo}, {48'd0, s_snap});
            s_snap = exp16;
            s_have = 1;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        do_reset(1);
        repeat (2) @(negedge clk);

        // Full sweep, issued back to back.
        for (int k = 0; k < 2; k++)
            for (int m = 0; m < 4; m++)
                for (int c = 0; c < 4; c++)
                    for (int t = 0; t < 2; t++)
                        step(1'b1, k[0], m[1:0], c[1:0], t[0], "");

        // R11: consecutive permitted reads, one apart.
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 2'd0, 2'd3, 1'b0, "R11");
        // R9: faults between good reads keep data.
        step(1'b1, 1'b0, 2'd0, 2'd0, 1'b0, "R3");
        step(1'b1, 1'b0, 2'd2, 2'd3, 1'b1, "R9");
        step(1'b1, 1'b1, 2'd0, 2'd2, 1'b0, "R9");
        step(1'b0, 1'b0, 2'd0, 2'd0, 1'b0, "");

        // Random mix.
        for (int i = 0; i < 3000; i++)
            step(($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), "");
        step(1'b0, 1'b0, 2'd0, 2'd0, 1'b0, "");

        // R2: reset in mid-run, then a read returns the edges since release.
        do_reset(2);
        repeat (4) @(negedge clk);
        step(1'b1, 1'b0, 2'd1, 2'd0, 1'b0, "R2");
        step(1'b0, 1'b0, 2'd0, 2'd0, 1'b0, "");

        // Let the narrow counter wrap.
        repeat (66000) step(1'b0, 1'b0, 2'd0, 2'd0, 1'b0, "");

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        end
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        end
        $finish;
    end
endmodule